// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power-control register of an 8-bit microcontroller and runs the state machine behind its low-power modes. Software writes the register over a simple special-function-register bus at one fixed address. Setting one bit stops the CPU clock while the peripherals keep running (idle). Setting another bit stops the oscillator, turns off the brown-out detector and powers down the flash (power-down). The block drives clock-gate enables for the CPU and peripheral domains, an oscillator enable, a watchdog enable, a brown-out detector enable and a flash power-down signal. The oscillator, flash, baud logic and clock divider are outside the block and see only these signals.

The block runs on an always-on clock. Wake-up from idle happens on any enabled interrupt or on any reset. Wake-up from power-down happens on a wake-capable interrupt or on a reset, and takes one of two forms that software selects. In the externally timed form, the CPU stays stopped for as long as the wake line is held. In the internally timed form, a counter holds the CPU clock off for a fixed number of cycles after the oscillator restarts. A power-off flag is set only by a cold reset and is kept through warm resets, so software can tell a cold start from a warm one.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control register is read and written at address 0x87. Bit 7 drives `baud_dbl` and bit 6 drives `fe_sel`. A write to any other address leaves the register unchanged, and a read of any other address returns 0x00.
- R2: A cold reset (`por_n` low) sets the register to 0x10. A warm reset (`ext_rst` or `bod_rst` high at a clock edge) clears every bit except bit 4, keeps bit 4 as it was, and returns the block to run mode.
- R3: Bit 4 (the power-off flag) can be set and cleared by a software write.
- R4: A write with bit 0 = 1 and bit 1 = 0 enters idle from the next cycle. In idle, `cpu_clk_en` = 0, `periph_clk_en` = 1, `osc_en` = 1 and `bod_en` = 1, and `wdt_en` follows `wdt_idle_en`.
- R5: In idle, `irq_wake` or `irq_pd_wake` returns the block to run on the next cycle, and bit 0 then reads 0.
- R6: A write with bit 1 = 1 enters power-down from the next cycle. In power-down, `cpu_clk_en`, `periph_clk_en`, `osc_en`, `bod_en` and `wdt_en` are all 0, and `flash_pd` = 1.
- R7: If bits 1 and 0 are written as 1 together, the block enters power-down, and the register then reads bit 1 = 1 and bit 0 = 0.
- R8: In power-down, `irq_wake` alone has no effect. `irq_pd_wake`, a warm reset or a cold reset ends power-down.
- R9: With bit 5 = 0, `osc_en` rises and `flash_pd` falls in the cycle after `irq_pd_wake` is sampled high. `cpu_clk_en` stays 0 while the line is held, and rises in the cycle after the line is sampled low. Bit 1 then reads 0.
- R10: With bit 5 = 1, after a wake request `cpu_clk_en` stays 0 with `osc_en` = 1 for exactly WAKE_CYCLES cycles (default 64), and the line's level during this time is ignored. After that the CPU resumes and bit 1 reads 0.
- R11: `wake_strobe` is high for exactly one cycle, the first run cycle after a power-down wake-up. It stays low when the block leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Cold (power-on) reset, active low, asynchronous |
| ext_rst | input | 1 | External reset pin, warm, active high, synchronous |
| bod_rst | input | 1 | Brown-out reset, warm, active high, synchronous |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (0x00 when the address does not match) |
| wdt_idle_en | input | 1 | Lets the watchdog run during idle |
| irq_wake | input | 1 | Any enabled interrupt request |
| irq_pd_wake | input | 1 | Enabled wake-capable interrupt (power-down wake line) |
| cpu_clk_en | output | 1 | CPU core clock-gate enable |
| periph_clk_en | output | 1 | Peripheral clock-gate enable |
| osc_en | output | 1 | Oscillator enable |
| wdt_en | output | 1 | Watchdog enable |
| bod_en | output | 1 | Brown-out detector enable |
| flash_pd | output | 1 | Flash power-down request |
| wake_strobe | output | 1 | One-cycle pulse to the interrupt controller after a power-down wake |
| baud_dbl | output | 1 | Baud-doubling control bit (bit 7) |
| fe_sel | output | 1 | Frame-error select bit (bit 6) |

## Verification
A wrong mode state shows at the enables in the very next cycle, because every enable is decoded straight from the state. A missed mode entry leaves `cpu_clk_en` high. A stuck power-down leaves `osc_en` low after the wake line has risen. A mode bit that hardware failed to clear shows on the first register read after the CPU resumes. A wake counter that is off by one moves the rise of `cpu_clk_en` and `wake_strobe` by one cycle against the count of cycles in which the oscillator is on. A power-off flag that a warm reset wrongly touches shows at the first read after the reset.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int WAKE_CYCLES = 64,
  parameter logic [7:0] CTL_ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst,
  input  logic       bod_rst,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       wdt_idle_en,
  input  logic       irq_wake,
  input  logic       irq_pd_wake,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       wdt_en,
  output logic       bod_en,
  output logic       flash_pd,
  output logic       wake_strobe,
  output logic       baud_dbl,
  output logic       fe_sel
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PDN, S_WEXT, S_WCNT} st_t;

  st_t           st;
  logic [7:0]    ctl_q;
  logic [CW-1:0] cnt;
  logic          strobe_q;

  wire hit    = (sfr_addr == CTL_ADDR);
  wire wr_hit = sfr_wr && hit;
  wire warm   = ext_rst || bod_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_RUN;
      ctl_q    <= 8'h10;
      cnt      <= '0;
      strobe_q <= 1'b0;
    end else if (warm) begin
      st       <= S_RUN;
      ctl_q    <= {3'b000, ctl_q[4], 4'b0000};
      cnt      <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      case (st)
        S_RUN: if (wr_hit) begin
          ctl_q <= {sfr_wdata[7:1], sfr_wdata[0] & ~sfr_wdata[1]};
          if (sfr_wdata[1])      st <= S_PDN;
          else if (sfr_wdata[0]) st <= S_IDLE;
        end
        S_IDLE: if (irq_wake || irq_pd_wake) begin
          st       <= S_RUN;
          ctl_q[0] <= 1'b0;
        end
        S_PDN: if (irq_pd_wake) begin
          st  <= ctl_q[5] ? S_WCNT : S_WEXT;
          cnt <= '0;
        end
        S_WEXT: if (!irq_pd_wake) begin
          st       <= S_RUN;
          ctl_q[1] <= 1'b0;
          strobe_q <= 1'b1;
        end
        S_WCNT: if (cnt == LAST) begin
          st       <= S_RUN;
          ctl_q[1] <= 1'b0;
          strobe_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign sfr_rdata     = hit ? ctl_q : 8'h00;
  assign cpu_clk_en    = (st == S_RUN);
  assign periph_clk_en = (st == S_RUN) || (st == S_IDLE);
  assign osc_en        = (st != S_PDN);
  assign bod_en        = (st != S_PDN);
  assign flash_pd      = (st == S_PDN);
  assign wdt_en        = (st == S_RUN) || ((st == S_IDLE) && wdt_idle_en);
  assign wake_strobe   = strobe_q;
  assign baud_dbl      = ctl_q[7];
  assign fe_sel        = ctl_q[6];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int WAKE_CYCLES = 64,
  parameter logic [7:0] CTL_ADDR = 8'h87
) (
  input logic       clk,
  input logic       por_n,
  input logic       ext_rst,
  input logic       bod_rst,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       bod_en,
  input logic       wdt_en,
  input logic       flash_pd,
  input logic       wake_strobe,
  input logic [7:0] ctl_q
);
  logic [15:0] wake_len;
  wire waking = osc_en && !periph_clk_en && !cpu_clk_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 wake_len <= '0;
    else if (ext_rst || bod_rst) wake_len <= '0;
    else if (waking)             wake_len <= (wake_len == 16'hFFFF) ? wake_len : wake_len + 1'b1;
    else                         wake_len <= '0;
  end

  p_pd_outputs_r6: assert property (@(posedge clk) disable iff (!por_n)
    flash_pd |-> (!osc_en && !bod_en && !cpu_clk_en && !periph_clk_en && !wdt_en));

  p_warm_keeps_flag_r2: assert property (@(posedge clk) disable iff (!por_n)
    (ext_rst || bod_rst) |=> (ctl_q[4] == $past(ctl_q[4])));

  p_pd_priority_r7: assert property (@(posedge clk) disable iff (!por_n)
    (sfr_wr && sfr_addr == CTL_ADDR && sfr_wdata[1] && cpu_clk_en && !ext_rst && !bod_rst)
      |=> (flash_pd && ctl_q[1:0] == 2'b10));

  p_idle_keeps_bod_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_clk_en && periph_clk_en) |-> (bod_en && osc_en));

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!por_n)
    wake_strobe |=> !wake_strobe);

  p_strobe_resume_r9: assert property (@(posedge clk) disable iff (!por_n)
    wake_strobe |-> (cpu_clk_en && !ctl_q[1]));

  p_timed_wake_len_r10: assert property (@(posedge clk) disable iff (!por_n)
    (wake_strobe && ctl_q[5]) |-> (wake_len == 16'(WAKE_CYCLES)));

  p_resume_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && !$past(cpu_clk_en) && !$past(ext_rst) && !$past(bod_rst)) |-> (ctl_q[1:0] == 2'b00));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.WAKE_CYCLES(WAKE_CYCLES), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .bod_rst(bod_rst),
  .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
  .bod_en(bod_en), .wdt_en(wdt_en), .flash_pd(flash_pd),
  .wake_strobe(wake_strobe), .ctl_q(ctl_q)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, por_n = 1'b0, ext_rst = 1'b0, bod_rst = 1'b0;
  logic [7:0] sfr_addr = 8'h87, sfr_wdata = 8'h00;
  logic sfr_wr = 1'b0, wdt_idle_en = 1'b0, irq_wake = 1'b0, irq_pd_wake = 1'b0;
  logic [7:0] sfr_rdata;
  logic cpu_clk_en, periph_clk_en, osc_en, wdt_en, bod_en, flash_pd, wake_strobe, baud_dbl, fe_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pwr_mode_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk); sfr_wr = 1'b0; sfr_addr = 8'h87;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sfr_addr = a; #1;
    chk(sfr_rdata, exp, tag);
    sfr_addr = 8'h87;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(8'h87, 8'h10, "R2 cold reset value");
    chk({cpu_clk_en, periph_clk_en, osc_en, bod_en, wdt_en, flash_pd, wake_strobe}, 7'b1111100, "R2 run outputs after reset");
  endtask

  task automatic t_regs;
    wr(8'h87, 8'hEC);
    rd_chk(8'h87, 8'hEC, "R1 readback");
    chk({baud_dbl, fe_sel}, 2'b11, "R1 bit7/bit6 outputs");
    chk(cpu_clk_en, 1'b1, "R1 plain write stays in run");
    wr(8'h88, 8'h13);
    rd_chk(8'h87, 8'hEC, "R1 other address write ignored");
    rd_chk(8'h88, 8'h00, "R1 other address reads zero");
    wr(8'h87, 8'h10);
    rd_chk(8'h87, 8'h10, "R3 software sets flag");
    wr(8'h87, 8'h00);
    rd_chk(8'h87, 8'h00, "R3 software clears flag");
  endtask

  task automatic t_warm;
    wr(8'h87, 8'hFC);
    pulse(ext_rst);
    rd_chk(8'h87, 8'h10, "R2 ext reset keeps flag set");
    wr(8'h87, 8'hEC);
    pulse(bod_rst);
    rd_chk(8'h87, 8'h00, "R2 brown-out reset keeps flag clear");
  endtask

  task automatic t_idle;
    wdt_idle_en = 1'b0;
    wr(8'h87, 8'h01);
    chk({cpu_clk_en, periph_clk_en, osc_en, bod_en, wdt_en}, 5'b01110, "R4 idle outputs, watchdog off");
    wdt_idle_en = 1'b1; #1;
    chk(wdt_en, 1'b1, "R4 watchdog follows idle enable");
    pulse(irq_wake);
    chk(cpu_clk_en, 1'b1, "R5 interrupt ends idle");
    chk(wake_strobe, 1'b0, "R11 no strobe after idle");
    rd_chk(8'h87, 8'h00, "R5 idle bit cleared");
    wr(8'h87, 8'h01);
    pulse(ext_rst);
    chk(cpu_clk_en, 1'b1, "R5 reset ends idle");
    wdt_idle_en = 1'b0;
  endtask

  task automatic t_pd_ext;
    wr(8'h87, 8'h02);
    chk({cpu_clk_en, periph_clk_en, osc_en, bod_en, wdt_en, flash_pd}, 6'b000001, "R6 power-down outputs");
    pulse(irq_wake);
    chk({osc_en, flash_pd}, 2'b01, "R8 plain interrupt ignored in power-down");
    @(negedge clk); irq_pd_wake = 1'b1;
    @(negedge clk);
    chk({osc_en, flash_pd, cpu_clk_en}, 3'b100, "R9 oscillator on after wake line");
    repeat (3) begin
      @(negedge clk);
      chk(cpu_clk_en, 1'b0, "R9 CPU held while line high");
    end
    irq_pd_wake = 1'b0;
    @(negedge clk);
    chk({cpu_clk_en, wake_strobe}, 2'b11, "R9 R11 resume with strobe");
    rd_chk(8'h87, 8'h00, "R9 power-down bit cleared");
    @(negedge clk);
    chk(wake_strobe, 1'b0, "R11 strobe lasts one cycle");
  endtask

  task automatic t_pd_int;
    int n = 0;
    wr(8'h87, 8'h22);
    chk(flash_pd, 1'b1, "R6 power-down entered");
    pulse(irq_pd_wake);
    while (!cpu_clk_en && n < 200) begin
      if (osc_en) n++;
      @(negedge clk);
    end
    chk(n, 64, "R10 timed wake length");
    chk(wake_strobe, 1'b1, "R11 strobe after timed wake");
    rd_chk(8'h87, 8'h20, "R10 power-down bit cleared, mode kept");
  endtask

  task automatic t_pd_int_held;
    int n = 0;
    wr(8'h87, 8'h22);
    @(negedge clk); irq_pd_wake = 1'b1;
    @(negedge clk);
    while (!cpu_clk_en && n < 200) begin
      n++;
      @(negedge clk);
    end
    irq_pd_wake = 1'b0;
    chk(n, 64, "R10 held line does not extend timed wake");
  endtask

  task automatic t_both;
    wr(8'h87, 8'h03);
    chk(flash_pd, 1'b1, "R7 power-down wins");
    rd_chk(8'h87, 8'h02, "R7 register reads power-down only");
    pulse(ext_rst);
    chk({cpu_clk_en, osc_en}, 2'b11, "R8 ext reset ends power-down");
    rd_chk(8'h87, 8'h00, "R8 mode bits cleared by reset");
    wr(8'h87, 8'h02);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1; #1;
    chk(cpu_clk_en, 1'b1, "R8 cold reset ends power-down");
    rd_chk(8'h87, 8'h10, "R2 cold reset sets flag");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_warm();
    t_idle();
    t_pd_ext();
    t_pd_int();
    t_pd_int_held();
    t_both();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule